// File: doc/BRIEF.md
# SPI Frame Integrity Checker

This block sits between an SPI slave bit sampler and a register file. It decides, one chip-select frame at a time, whether a host write may commit. While chip select is low it counts the sampled data bits and runs a serial 8-bit CRC over the payload. When chip select returns high it checks two things: the exact bit count and the received CRC byte. A write commits only when both checks pass.

The two kinds of failure are kept apart. A frame of the wrong length sets a sticky length-error flag. A frame of the right length with a bad CRC sets a sticky CRC-error flag. Either flag drives an active-low interrupt request. Each flag is cleared by its own write-one-to-clear strobe. An 8-bit scratchpad register is updated by committed writes to its address, so the host can write a value, read it back and confirm that the link works.

A frame is ADDR_W+DATA_W+9 bits long (24 by default) and is sent MSB first:
- 1 write bit
- ADDR_W address bits
- DATA_W data bits
- 8 CRC bits

Top module: `spi_frame_guard`

## Requirements
- R1: After synchronous reset: `wr_commit`=0, `crc_err`=0, `len_err`=0, `irq_n`=1, `scratch_q`=0.
- R2: Frame layout, MSB first, 24 bits by default: bit 23 is the write flag (1 = write), bits 22:16 are the address, bits 15:8 are the data and bits 7:0 are the CRC. For a valid write frame, `wr_commit` pulses high for exactly one clock, in the cycle after the clock edge that first sees `cs_n` high, with `wr_addr`/`wr_data` carrying the frame fields.
- R3: The CRC uses polynomial 0x2F and initial value 0xFF. It is computed MSB first over all bits before the CRC byte. A frame of correct length whose CRC byte differs commits nothing, sets `crc_err` and leaves `len_err` unchanged.
- R4: A frame with more or fewer than 24 sampled bits (zero included) commits nothing and sets `len_err`. Such a frame does not set `crc_err`.
- R5: A frame of correct length with a correct CRC and the write flag at 0 commits nothing and sets no flag.
- R6: Flags are sticky. Each clears in the cycle after its own strobe (`clr_crc_err`, `clr_len_err`) and the other flag is unaffected. A new error in the same cycle as the strobe wins over the clear.
- R7: `irq_n` is low exactly when at least one flag is set, in the same cycle as the flags.
- R8: `scratch_q` takes `wr_data` one cycle after a commit to address 0x0F. Writes to other addresses leave it unchanged, and so do failed frames to 0x0F.
- R9: `bit_stb` pulses while `cs_n` is high are ignored: a correct frame sent afterwards still commits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset |
| cs_n | input | 1 | synchronized chip select, active low |
| bit_stb | input | 1 | one-cycle strobe per sampled data bit |
| bit_val | input | 1 | sampled data bit value |
| clr_crc_err | input | 1 | write-one-to-clear strobe for crc_err |
| clr_len_err | input | 1 | write-one-to-clear strobe for len_err |
| wr_commit | output | 1 | one-cycle write commit enable |
| wr_addr | output | ADDR_W | address of the committed write |
| wr_data | output | DATA_W | data of the committed write |
| crc_err | output | 1 | sticky CRC mismatch flag |
| len_err | output | 1 | sticky bit-count error flag |
| irq_n | output | 1 | interrupt request, active low |
| scratch_q | output | DATA_W | scratchpad register value |

## Verification
The bench sends valid write frames, valid read frames, frames with one flipped CRC bit, and frames that are short or long by one to several bits, including empty chip-select pulses. Between these frames it mixes clear strobes. A flipped CRC bit on a full-length frame must raise only the CRC flag, while a length error must raise only the length flag; this shows the two checks are separate and that CRC judgement is gated by length. Scratchpad writes, near-miss addresses and stray strobes outside a frame show that only good write frames reach storage.

// File: rtl/spi_fic_pkg.sv
package spi_fic_pkg;
  localparam int CRC_W = 8;

  function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] crc,
                                                input logic             din,
                                                input logic [CRC_W-1:0] poly);
    logic fb;
    fb = crc[CRC_W-1] ^ din;
    return {crc[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/spi_fic_collect.sv
module spi_fic_collect
  import spi_fic_pkg::*;
#(
  parameter int               FRAME_BITS = 24,
  parameter logic [CRC_W-1:0] CRC_POLY   = 8'h2F,
  parameter logic [CRC_W-1:0] CRC_INIT   = 8'hFF,
  localparam int              PAY_BITS   = FRAME_BITS - CRC_W,
  localparam int              CNT_W      = $clog2(FRAME_BITS + 2)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_n,
  input  logic                  bit_stb,
  input  logic                  bit_val,
  output logic [CNT_W-1:0]      bit_cnt,
  output logic [FRAME_BITS-1:0] shreg,
  output logic [CRC_W-1:0]      crc_acc
);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(FRAME_BITS + 1);
  localparam logic [CNT_W-1:0] CNT_PAY = CNT_W'(PAY_BITS);

  always_ff @(posedge clk) begin
    if (rst || cs_n) begin
      bit_cnt <= '0;
      shreg   <= '0;
      crc_acc <= CRC_INIT;
    end else if (bit_stb) begin
      shreg <= {shreg[FRAME_BITS-2:0], bit_val};
      if (bit_cnt != CNT_SAT) bit_cnt <= bit_cnt + 1'b1;
      if (bit_cnt < CNT_PAY) crc_acc <= crc_step(crc_acc, bit_val, CRC_POLY);
    end
  end
endmodule

// File: rtl/spi_fic_judge.sv
module spi_fic_judge
  import spi_fic_pkg::*;
#(
  parameter int  ADDR_W     = 7,
  parameter int  DATA_W     = 8,
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W + CRC_W,
  localparam int CNT_W      = $clog2(FRAME_BITS + 2)
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  cs_n,
  input  logic                  clr_crc_err,
  input  logic                  clr_len_err,
  input  logic [CNT_W-1:0]      bit_cnt,
  input  logic [FRAME_BITS-1:0] shreg,
  input  logic [CRC_W-1:0]      crc_acc,
  output logic                  wr_commit,
  output logic [ADDR_W-1:0]     wr_addr,
  output logic [DATA_W-1:0]     wr_data,
  output logic                  crc_err,
  output logic                  len_err,
  output logic                  irq_n
);
  logic cs_d;
  logic frame_end, len_ok, crc_ok, is_write;
  logic crc_set, len_set, crc_nxt, len_nxt;

  always_comb begin
    frame_end = cs_n && !cs_d;
    len_ok    = (bit_cnt == CNT_W'(FRAME_BITS));
    crc_ok    = (crc_acc == shreg[CRC_W-1:0]);
    is_write  = shreg[FRAME_BITS-1];
    len_set   = frame_end && !len_ok;
    crc_set   = frame_end && len_ok && !crc_ok;
    crc_nxt   = crc_set || (crc_err && !clr_crc_err);
    len_nxt   = len_set || (len_err && !clr_len_err);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cs_d      <= 1'b1;
      wr_commit <= 1'b0;
      wr_addr   <= '0;
      wr_data   <= '0;
      crc_err   <= 1'b0;
      len_err   <= 1'b0;
      irq_n     <= 1'b1;
    end else begin
      cs_d      <= cs_n;
      wr_commit <= frame_end && len_ok && crc_ok && is_write;
      if (frame_end) begin
        wr_addr <= shreg[FRAME_BITS-2 -: ADDR_W];
        wr_data <= shreg[CRC_W +: DATA_W];
      end
      crc_err <= crc_nxt;
      len_err <= len_nxt;
      irq_n   <= !(crc_nxt || len_nxt);
    end
  end
endmodule

// File: rtl/spi_fic_scratch.sv
module spi_fic_scratch #(
  parameter int              ADDR_W       = 7,
  parameter int              DATA_W       = 8,
  parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 7'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_commit,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] scratch_q
);
  always_ff @(posedge clk) begin
    if (rst) scratch_q <= '0;
    else if (wr_commit && wr_addr == SCRATCH_ADDR) scratch_q <= wr_data;
  end
endmodule

// File: rtl/spi_frame_guard.sv
module spi_frame_guard
  import spi_fic_pkg::*;
#(
  parameter int                ADDR_W       = 7,
  parameter int                DATA_W       = 8,
  parameter logic [CRC_W-1:0]  CRC_POLY     = 8'h2F,
  parameter logic [CRC_W-1:0]  CRC_INIT     = 8'hFF,
  parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 7'h0F
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              bit_stb,
  input  logic              bit_val,
  input  logic              clr_crc_err,
  input  logic              clr_len_err,
  output logic              wr_commit,
  output logic [ADDR_W-1:0] wr_addr,
  output logic [DATA_W-1:0] wr_data,
  output logic              crc_err,
  output logic              len_err,
  output logic              irq_n,
  output logic [DATA_W-1:0] scratch_q
);
  localparam int FRAME_BITS = 1 + ADDR_W + DATA_W + CRC_W;
  localparam int CNT_W      = $clog2(FRAME_BITS + 2);

  logic [CNT_W-1:0]      bit_cnt;
  logic [FRAME_BITS-1:0] shreg;
  logic [CRC_W-1:0]      crc_acc;

  spi_fic_collect #(.FRAME_BITS(FRAME_BITS), .CRC_POLY(CRC_POLY), .CRC_INIT(CRC_INIT)) u_collect (
    .clk(clk), .rst(rst), .cs_n(cs_n), .bit_stb(bit_stb), .bit_val(bit_val),
    .bit_cnt(bit_cnt), .shreg(shreg), .crc_acc(crc_acc)
  );

  spi_fic_judge #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_judge (
    .clk(clk), .rst(rst), .cs_n(cs_n), .clr_crc_err(clr_crc_err), .clr_len_err(clr_len_err),
    .bit_cnt(bit_cnt), .shreg(shreg), .crc_acc(crc_acc),
    .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data),
    .crc_err(crc_err), .len_err(len_err), .irq_n(irq_n)
  );

  spi_fic_scratch #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .SCRATCH_ADDR(SCRATCH_ADDR)) u_scratch (
    .clk(clk), .rst(rst), .wr_commit(wr_commit), .wr_addr(wr_addr), .wr_data(wr_data),
    .scratch_q(scratch_q)
  );
endmodule

// File: rtl/spi_frame_guard_chk.sv
module spi_frame_guard_chk #(
  parameter int                ADDR_W       = 7,
  parameter int                DATA_W       = 8,
  parameter logic [ADDR_W-1:0] SCRATCH_ADDR = 7'h0F
) (
  input logic              clk,
  input logic              rst,
  input logic              cs_n,
  input logic              clr_crc_err,
  input logic              clr_len_err,
  input logic              wr_commit,
  input logic [ADDR_W-1:0] wr_addr,
  input logic              crc_err,
  input logic              len_err,
  input logic              irq_n,
  input logic [DATA_W-1:0] scratch_q
);
  // R2: commit is a single-cycle pulse
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    wr_commit |=> !wr_commit);
  // R2: commit only follows a chip-select rising edge
  a_r2_after_cs_rise: assert property (@(posedge clk) disable iff (rst)
    wr_commit |-> ($past(cs_n) && !$past(cs_n, 2)));
  // R3: a new CRC error never comes with a commit
  a_r3_no_commit_on_crc: assert property (@(posedge clk) disable iff (rst)
    $rose(crc_err) |-> !wr_commit);
  // R4: a new length error never comes with a commit
  a_r4_no_commit_on_len: assert property (@(posedge clk) disable iff (rst)
    $rose(len_err) |-> !wr_commit);
  // R6: flags hold without their clear strobe
  a_r6_crc_sticky: assert property (@(posedge clk) disable iff (rst)
    (crc_err && !clr_crc_err) |=> crc_err);
  a_r6_len_sticky: assert property (@(posedge clk) disable iff (rst)
    (len_err && !clr_len_err) |=> len_err);
  // R7: interrupt tracks the flags
  a_r7_irq_low: assert property (@(posedge clk) disable iff (rst)
    (crc_err || len_err) |-> !irq_n);
  a_r7_irq_high: assert property (@(posedge clk) disable iff (rst)
    (!crc_err && !len_err) |-> irq_n);
  // R8: scratchpad changes only after a commit to its address
  a_r8_scratch_source: assert property (@(posedge clk) disable iff (rst)
    !$stable(scratch_q) |-> $past(wr_commit && wr_addr == SCRATCH_ADDR));
endmodule

bind spi_frame_guard spi_frame_guard_chk #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SCRATCH_ADDR(SCRATCH_ADDR)
) u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .clr_crc_err(clr_crc_err), .clr_len_err(clr_len_err),
  .wr_commit(wr_commit), .wr_addr(wr_addr), .crc_err(crc_err), .len_err(len_err),
  .irq_n(irq_n), .scratch_q(scratch_q)
);

// File: tb/sim_spi_frame_guard.sv
`timescale 1ns/1ps
module sim_spi_frame_guard;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       cs_n = 1'b1, bit_stb = 1'b0, bit_val = 1'b0;
  logic       clr_crc_err = 1'b0, clr_len_err = 1'b0;
  logic       wr_commit, crc_err, len_err, irq_n;
  logic [6:0] wr_addr;
  logic [7:0] wr_data, scratch_q;

  int  n_cmp = 0, n_bad = 0;
  bit  done = 0;
  logic e_crc = 0, e_len = 0;
  logic [7:0] e_scr = 0;

  always #2.5 clk = ~clk;

  spi_frame_guard u0 (.*);

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] crc_of(input logic [15:0] pay);
    logic [7:0] c = 8'hFF;
    for (int i = 15; i >= 0; i--) begin
      logic fb = c[7] ^ pay[i];
      c = {c[6:0], 1'b0} ^ (fb ? 8'h2F : 8'h00);
    end
    return c;
  endfunction

  function automatic logic [23:0] mk(input logic w, input logic [6:0] a, input logic [7:0] d);
    logic [15:0] p = {w, a, d};
    return {p, crc_of(p)};
  endfunction

  task automatic send(input logic [31:0] v, input int n);
    @(negedge clk) cs_n = 1'b0;
    for (int i = n - 1; i >= 0; i--) begin
      @(negedge clk) begin bit_val = v[i]; bit_stb = 1'b1; end
      @(negedge clk) bit_stb = 1'b0;
    end
    @(negedge clk) cs_n = 1'b1;
  endtask

  // Send a frame and check one and two cycles after cs_n rises
  task automatic run(input logic [31:0] v, input int n, input int kind, input string req);
    logic w = v[23];
    logic [6:0] a = v[22:16];
    logic [7:0] d = v[15:8];
    logic good = (kind == 0) && w;
    send(v, n);
    if (kind == 1) e_crc = 1;
    if (kind == 2) e_len = 1;
    @(negedge clk);
    check({req, " commit"}, wr_commit, good);
    if (good) begin
      check({req, " addr"}, wr_addr, a);
      check({req, " data"}, wr_data, d);
    end
    check({req, " crc_err"}, crc_err, e_crc);
    check({req, " len_err"}, len_err, e_len);
    check({req, " irq_n"}, irq_n, !(e_crc || e_len));
    if (good && a == 7'h0F) e_scr = d;
    @(negedge clk);
    check("R2 pulse end", wr_commit, 0);
    check({req, " scratch"}, scratch_q, e_scr);
  endtask

  task automatic clear(input logic c_crc, input logic c_len);
    @(negedge clk) begin clr_crc_err = c_crc; clr_len_err = c_len; end
    @(negedge clk) begin clr_crc_err = 0; clr_len_err = 0; end
    if (c_crc) e_crc = 0;
    if (c_len) e_len = 0;
    check("R6 crc after clear", crc_err, e_crc);
    check("R6 len after clear", len_err, e_len);
    check("R7 irq after clear", irq_n, !(e_crc || e_len));
  endtask

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      n_cmp++; n_bad++;
      $display("FAIL watchdog: actual timeout expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R1 commit", wr_commit, 0);
    check("R1 crc_err", crc_err, 0);
    check("R1 len_err", len_err, 0);
    check("R1 irq_n", irq_n, 1);
    check("R1 scratch", scratch_q, 0);

    // R2/R8: scratchpad write then a different address
    run({8'h0, mk(1, 7'h0F, 8'hA5)}, 24, 0, "R2 R8 scratch write");
    run({8'h0, mk(1, 7'h0E, 8'h3C)}, 24, 0, "R8 other addr");
    // R5: read frame
    run({8'h0, mk(0, 7'h0F, 8'h77)}, 24, 0, "R5 read frame");
    // R3: flipped CRC bit on scratch address
    run({8'h0, mk(1, 7'h0F, 8'h11) ^ 24'h000001}, 24, 1, "R3 bad crc");
    clear(1, 0);
    // R4: short, long, empty
    run({8'h0, mk(1, 7'h0F, 8'h22)}, 23, 2, "R4 short");
    run({mk(1, 7'h0F, 8'h22), 8'h5A}, 25, 2, "R4 long");
    run(32'h0, 0, 2, "R4 empty");
    // R6: crc error set while len_err is cleared alone
    run({8'h0, mk(1, 7'h01, 8'h01) ^ 24'h000080}, 24, 1, "R3 R6 crc with len");
    clear(0, 1);
    check("R6 crc kept", crc_err, 1);
    clear(1, 0);
    // R6: new error in the same cycle as the clear strobe wins
    send({8'h0, mk(1, 7'h02, 8'h02)}, 20);
    clr_len_err = 1'b1;
    @(negedge clk) clr_len_err = 1'b0;
    check("R6 set wins", len_err, 1);
    e_len = 1;
    clear(0, 1);
    // R9: stray strobes with cs_n high
    repeat (5) begin
      @(negedge clk) begin bit_stb = 1; bit_val = 1; end
      @(negedge clk) bit_stb = 0;
    end
    run({8'h0, mk(1, 7'h0F, 8'hC3)}, 24, 0, "R9 stray strobes");

    // Random mix
    for (int k = 0; k < 60; k++) begin
      logic w = 1'($urandom);
      logic [6:0] a = ($urandom % 3 == 0) ? 7'h0F : 7'($urandom);
      logic [7:0] d = 8'($urandom);
      int kind = $urandom % 3;
      logic [23:0] f = mk(w, a, d);
      if (kind == 0) run({8'h0, f}, 24, 0, "R2 R5 R8 random");
      else if (kind == 1) run({8'h0, f ^ (24'h1 << ($urandom % 8))}, 24, 1, "R3 random");
      else begin
        int n = ($urandom % 2) ? 24 + 1 + ($urandom % 8) : ($urandom % 24);
        run({f, 8'($urandom)} >> (32 - n), n, 2, "R4 random");
      end
      if ($urandom % 4 == 0) clear(1'($urandom), 1'($urandom));
    end

    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule